// File: doc/BRIEF.md
# I2C Command Frame Receiver

This block is the serial front end of a two-channel digital potentiometer controller. It oversamples the I2C lines with the system clock and detects START, repeated START and STOP conditions. It then checks the first byte against a 7-bit slave address. The upper five address bits are a fixed prefix and the lower two come from strap pins, so four controllers can share one bus.

A write frame is made of the address byte, an instruction byte and two data bytes. When the last of these bytes has been shifted in, the receiver raises a one-cycle strobe to the command executor. The strobe carries the instruction and a 10-bit payload. The payload is the whole first data byte followed by the top two bits of the second one. A read frame returns a 10-bit value supplied by the executor, packed into two bytes in the same layout. The receiver only pulls SDA low through an open-drain enable. It never drives SDA high.

Top module: `potctl_i2c_rx`

## Requirements
- R1: An address byte whose upper seven bits equal {5'b01011, strap_i[1], strap_i[0]} is acknowledged: SDA is held low through the ninth SCL high phase. Bit 0 of the address byte selects write (0) or read (1).
- R2: An address byte that does not match gets no acknowledge. Every later byte up to the next START also gets no acknowledge, and no command is issued.
- R3: After a matching write address, the next three bytes are taken as instruction, data-high and data-low. Once the third of them is received, cmd_valid is high for exactly one clock cycle with cmd_instr set to the instruction byte and cmd_data = {data-high[7:0], data-low[7:6]}. Bits 5:0 of data-low have no effect.
- R4: The instruction byte and both data bytes of a write frame are each acknowledged.
- R5: A STOP that arrives before all four bytes of a write frame have been received issues no command.
- R6: A repeated START that arrives before a write frame is complete discards the partial frame. The bytes that follow it are decoded as a fresh frame, starting with an address byte.
- R7: A read frame issues no command. It sends rd_value[9:2] and then {rd_value[1:0], 6'b000000}, each MSB first, using rd_value as captured when the address byte is acknowledged. The second byte is sent only if the master acknowledges the first one. After a master NACK the line is left released.
- R8: sda_oe is asserted only while SCL is low. An acknowledge is released after the ninth SCL falling edge. SDA is never pulled low outside an acknowledge slot or a read byte.
- R9: After reset sda_oe and cmd_valid are both 0.
- R10: In a write frame, any byte after the fourth gets no acknowledge and issues no further command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 2 | Pin-strapped low two address bits |
| rd_value | input | 10 | Value returned by a read frame |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_instr | output | 8 | Instruction byte of the command |
| cmd_data | output | 10 | 10-bit payload of the command |

## Verification
Write frames are sent with payloads that put ones and zeros in both payload halves and in the ignored low bits. This separates a correct bit extraction from a byte swap or a misplaced bit. Truncated frames show that a partial frame is discarded: some end with a STOP and some are cut short by a repeated START followed by a full frame. Over-long frames show that only the fourth byte triggers a command. Address bytes are tried with both strap settings, and both a matching and a non-matching value are used for each, so the strap pins are checked to be decoded in their own positions. Reads end with a master ACK in one run and a NACK in another, which checks both the byte order and the release of the line.

// File: rtl/potctl_i2c_rx.sv
module potctl_i2c_rx #(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  input  logic [9:0] rd_value,
  output logic       sda_oe,
  output logic       cmd_valid,
  output logic [7:0] cmd_instr,
  output logic [9:0] cmd_data
);
  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_RX    = 3'd1;
  localparam logic [2:0] ST_ACK   = 3'd2;
  localparam logic [2:0] ST_TX    = 3'd3;
  localparam logic [2:0] ST_TXACK = 3'd4;
  localparam logic [2:0] LAST_WR  = 3'd3;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic [2:0] state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, instr_q, hi_q, tx_lo;
  logic [2:0] byte_idx;
  logic       is_read, mst_ack;

  assign scl_s = scl_ff[1];
  assign sda_s = sda_ff[1];

  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire addr_hit = shreg[7:1] == {ADDR_PREFIX, strap_i};
  wire byte_end = scl_fall && bitcnt == 4'd8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      instr_q   <= '0;
      hi_q      <= '0;
      tx_lo     <= '0;
      byte_idx  <= '0;
      is_read   <= 1'b0;
      mst_ack   <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_instr <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_c) begin
        state    <= ST_RX;
        bitcnt   <= '0;
        byte_idx <= '0;
        is_read  <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
            if (byte_end) begin
              bitcnt <= '0;
              if (byte_idx == 3'd0) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  state   <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (byte_idx > LAST_WR) begin
                state <= ST_IDLE;
              end else begin
                sda_oe <= 1'b1;
                state  <= ST_ACK;
                case (byte_idx)
                  3'd1: instr_q <= shreg;
                  3'd2: hi_q    <= shreg;
                  default: begin
                    cmd_valid <= 1'b1;
                    cmd_instr <= instr_q;
                    cmd_data  <= {hi_q, shreg[7:6]};
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              byte_idx <= byte_idx + 3'd1;
              bitcnt   <= '0;
              if (is_read) begin
                shreg  <= rd_value[9:2];
                tx_lo  <= {rd_value[1:0], 6'b000000};
                sda_oe <= ~rd_value[9];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                bitcnt <= bitcnt + 4'd1;
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) mst_ack <= ~sda_s;
            if (scl_fall) begin
              if (mst_ack && byte_idx == 3'd1) begin
                byte_idx <= 3'd2;
                bitcnt   <= '0;
                shreg    <= tx_lo;
                sda_oe   <= ~tx_lo[7];
                state    <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/potctl_i2c_rx_chk.sv
module potctl_i2c_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       cmd_valid,
  input logic       is_read,
  input logic [2:0] state,
  input logic [2:0] byte_idx
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R3
  AST_STROBE_FOURTH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> byte_idx == 3'd3); // R3
  AST_NO_CMD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !is_read); // R7
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == 3'd0 |-> !sda_oe); // R2
endmodule

bind potctl_i2c_rx potctl_i2c_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .cmd_valid(cmd_valid), .is_read(is_read), .state(state), .byte_idx(byte_idx)
);

// File: tb/test_potctl_i2c_rx.sv
module test_potctl_i2c_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [9:0] rd_value = '0;
  logic sda_oe, cmd_valid;
  logic [7:0] cmd_instr;
  logic [9:0] cmd_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0, bus_viol = 0, cyc = 0;
  bit may_drive = 0, done = 0;
  logic [17:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  potctl_i2c_rx i_potctl_i2c_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .rd_value(rd_value), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
    .cmd_instr(cmd_instr), .cmd_data(cmd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] cmd_of(logic [7:0] i, logic [7:0] d1, logic [7:0] d0);
    return {i, d1, d0[7:6]};
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && sda_oe && !may_drive) bus_viol++;
    if (cmd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected strobe", int'({cmd_instr, cmd_data}), 0);
      else begin
        check({cmd_instr, cmd_data} == exp_q[0], "R3 command fields",
              int'({cmd_instr, cmd_data}), int'(exp_q[0]));
        exp_q.delete(0);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop;
    may_drive = 0;
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit rel_chk, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1'b1;   tick(Q);
      scl = 1'b0;
      if (i == 0) may_drive = 1;
      tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q/2);
    ack = !sda_line;
    tick(Q/2);
    scl = 1'b0;   tick(Q);
    if (rel_chk) begin
      may_drive = 0;
      check(!sda_oe, "R8 ack released after ninth fall", int'(sda_oe), 0);
    end
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    may_drive = 1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q/2);
      b[i] = sda_line;
      tick(Q/2);
      scl = 1'b0;
    end
    tick(Q/2);
    sda_m = !give_ack; tick(Q/2);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(Q/2);
    sda_m = 1'b1; tick(Q/2);
  endtask

  task automatic send(input logic [39:0] bs, input int n, output logic [4:0] acks);
    acks = '0;
    bus_start;
    for (int k = 0; k < n; k++) begin
      bit a;
      wr_byte(bs[39-8*k -: 8], 1'b1, a);
      acks[k] = a;
    end
  endtask

  initial begin
    logic [4:0] ak;
    logic [7:0] b1, b0;
    bit a;
    tick(5);
    check(!sda_oe && !cmd_valid, "R9 reset outputs", int'({sda_oe, cmd_valid}), 0);
    rst_n = 1'b1;
    tick(10);

    // R1 R3 R4: full write frame, strap 10 -> address 0x5C
    exp_q.push_back(cmd_of(8'h3A, 8'hB5, 8'hEA));
    send({8'h5C, 8'h3A, 8'hB5, 8'hEA, 8'h00}, 4, ak);
    bus_stop; tick(4);
    check(ak[3:0] == 4'hF, "R1 R4 all four bytes acked", int'(ak), 'hF);
    check(exp_q.size() == 0, "R3 strobe delivered", exp_q.size(), 0);

    // R3: payload extremes, ignored low bits
    exp_q.push_back(cmd_of(8'hFF, 8'h00, 8'h3F));
    send({8'h5C, 8'hFF, 8'h00, 8'h3F, 8'h00}, 4, ak);
    bus_stop;
    exp_q.push_back(cmd_of(8'h00, 8'hFF, 8'hC0));
    send({8'h5C, 8'h00, 8'hFF, 8'hC0, 8'h00}, 4, ak);
    bus_stop; tick(4);
    check(exp_q.size() == 0, "R3 extreme payloads delivered", exp_q.size(), 0);

    // R2: mismatched address, nothing acked afterwards
    send({8'h5A, 8'h11, 8'h22, 8'h33, 8'h00}, 4, ak);
    bus_stop; tick(4);
    check(ak == 5'b0, "R2 mismatch never acked", int'(ak), 0);
    check(exp_q.size() == 0, "R2 no command on mismatch", exp_q.size(), 0);

    // R5: STOP after three bytes
    send({8'h5C, 8'h12, 8'h34, 8'h00, 8'h00}, 3, ak);
    bus_stop; tick(4);
    check(ak[2:0] == 3'b111, "R4 partial bytes acked", int'(ak), 7);

    // R6: repeated START after two bytes, then a full frame
    send({8'h5C, 8'h55, 8'h66, 8'h00, 8'h00}, 2, ak);
    exp_q.push_back(cmd_of(8'h81, 8'h00, 8'hC0));
    send({8'h5C, 8'h81, 8'h00, 8'hC0, 8'h00}, 4, ak);
    bus_stop; tick(4);
    check(ak[3:0] == 4'hF, "R6 frame after restart acked", int'(ak), 'hF);
    check(exp_q.size() == 0, "R5 R6 only the complete frame issued", exp_q.size(), 0);

    // R10: fifth byte not acked, single command
    exp_q.push_back(cmd_of(8'h21, 8'h43, 8'h80));
    send({8'h5C, 8'h21, 8'h43, 8'h80, 8'h99}, 5, ak);
    bus_stop; tick(4);
    check(ak == 5'b01111, "R10 extra byte nacked", int'(ak), 'hF);
    check(exp_q.size() == 0, "R10 single command", exp_q.size(), 0);

    // R7: read with master ack then nack
    rd_value = 10'h2C9;
    bus_start;
    wr_byte(8'h5D, 1'b0, a);
    check(a, "R7 read address acked", int'(a), 1);
    rd_value = 10'h000;
    rd_byte(1'b1, b1);
    rd_byte(1'b0, b0);
    bus_stop; tick(4);
    check(b1 == 8'hB2, "R7 read high byte", b1, 'hB2);
    check(b0 == 8'h40, "R7 read low byte", b0, 'h40);
    check(exp_q.size() == 0, "R7 no command on read", exp_q.size(), 0);

    // R7: master nack on first byte ends the transfer
    rd_value = 10'h155;
    bus_start;
    wr_byte(8'h5D, 1'b0, a);
    rd_byte(1'b0, b1);
    rd_byte(1'b0, b0);
    bus_stop; tick(4);
    check(b1 == 8'h55, "R7 read after nack first byte", b1, 'h55);
    check(b0 == 8'hFF, "R7 line released after nack", b0, 'hFF);

    // R1: strap 01 moves the address to 0x5A
    strap = 2'b01;
    tick(4);
    send({8'h5C, 8'h01, 8'h02, 8'h03, 8'h00}, 4, ak);
    bus_stop;
    check(ak == 5'b0, "R1 old address rejected after strap change", int'(ak), 0);
    exp_q.push_back(cmd_of(8'h96, 8'h69, 8'h7F));
    send({8'h5A, 8'h96, 8'h69, 8'h7F, 8'h00}, 4, ak);
    bus_stop; tick(4);
    check(ak[3:0] == 4'hF, "R1 new strap address acked", int'(ak), 'hF);
    check(exp_q.size() == 0, "R1 R3 command with new strap", exp_q.size(), 0);

    check(bus_viol == 0, "R8 SDA pulled only in ack or read slots", bus_viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule